// File: doc/BRIEF.md
# Cache Configuration Tuner

The tuner searches for the lowest-energy cache setting of each core, changing one cache parameter at a time. A session starts from the smallest setting, measures it, then steps the cache size upward, then the line size, then the associativity. After each step it asks the surrounding system to run the workload with the trial setting. It then takes the run's statistics for the core under tuning and turns them into an energy figure with a five-step multiply-accumulate. The tuner keeps a step only when the new energy is strictly below the best figure so far.

Several cores share one tuner. They are served in order. A core-select output picks which core's statistics reach the energy datapath and which core's configuration field is being changed. The energy coefficients arrive on input ports. Measuring the statistics belongs to the surrounding system.

Top module: `cache_tuner_ctrl`

## Requirements
- R1: After reset, `busy_o` and `run_req_o` are low and every configuration field is zero. While `start_i` is low in idle, the tuner stays idle.
- R2: A high `start_i` sampled in idle raises `busy_o` on the next cycle. `busy_o` stays high until the last core's search ends.
- R3: For each core, the first run uses the all-zero setting. The search then tunes size, then line size, then associativity, and each trial raises only the parameter under tuning by one index.
- R4: The energy of a run is the sum of five products: accesses×dynamic coefficient, total_cycles×static coefficient, write_backs×write-back coefficient, miss_cycles×fill coefficient and miss_cycles×stall coefficient. The products are accumulated one per cycle after an internal calculation start. The done strobe comes six cycles after that start.
- R5: A trial whose energy is strictly lower than the best so far is kept, and the next index of the same parameter is tried. An equal or higher energy restores the previous index and moves on to the next parameter.
- R6: When a kept trial reaches the largest index of its parameter, the search moves on to the next parameter without another trial of that parameter.
- R7: Each core's field in `cfg_o` is CFG_W = 7 bits, core k at bits [7k+6:7k]. Bits [6:4] hold the size index (0..4 meaning 2, 4, 8, 16 and 32 KB). Bits [3:2] hold the line index (0..2 meaning 16, 32 and 64 bytes). Bits [1:0] hold the ways index (0..2 meaning 1, 2 and 4 ways). No field ever exceeds its largest index.
- R8: Cores are tuned in order 0 to N_CORES-1, and `core_sel_o` shows the core under tuning. Only that core's slot of each statistics input affects the result.
- R9: `run_req_o` stays high, with the configuration unchanged, until `run_done_i` is sampled high. The statistics must be valid while `run_done_i` is high and must stay so through the calculation.
- R10: At the end of a session `busy_o` falls and every core's field holds its final setting until the next session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning session |
| busy_o | output | 1 | Session in progress |
| run_req_o | output | 1 | Request a workload run with the current trial setting |
| run_done_i | input | 1 | Run finished, statistics valid |
| core_sel_o | output | CORE_W | Core under tuning |
| cfg_o | output | N_CORES*CFG_W | Per-core configuration fields |
| accesses_i | input | N_CORES*STAT_W | Access counts, one slot per core |
| cycles_i | input | N_CORES*STAT_W | Total cycle counts per core |
| miss_cycles_i | input | N_CORES*STAT_W | Miss cycle counts per core |
| write_backs_i | input | N_CORES*STAT_W | Write-back counts per core |
| coef_dyn_i | input | COEF_W | Dynamic energy coefficient |
| coef_static_i | input | COEF_W | Static energy coefficient |
| coef_wb_i | input | COEF_W | Write-back energy coefficient |
| coef_fill_i | input | COEF_W | Cache fill energy coefficient |
| coef_stall_i | input | COEF_W | CPU stall energy coefficient |

## Verification
The bench builds the tuner with its default parameters: two cores, five size values and three line and ways values, with 32-bit statistics and a 48-bit accumulator. With two cores the hand-off from one core to the next and the statistics select can be reached, because the slot of the core not under tuning carries all-ones values. The five-entry size range lets one session climb to the top index and another stop midway. Tables of energy costs per core produce ties, early rejections and improvements that reach the largest index, so the restore rule and the strict comparison are both exercised.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PARAM, ST_VALUE, ST_RUN, ST_CALC} tune_st_e;
  // order of this enum is the order parameters are tuned
  typedef enum logic [1:0] {PAR_NONE, PAR_SIZE, PAR_LINE, PAR_WAYS} tune_par_e;
  localparam int unsigned N_TERMS = 5;
endpackage

// File: rtl/tuner_stat_mux.sv
module tuner_stat_mux #(
  parameter int N_CORES = 2,
  parameter int STAT_W  = 32,
  parameter int CORE_W  = 1
) (
  input  logic [CORE_W-1:0]         sel_i,
  input  logic [N_CORES*STAT_W-1:0] accesses_i,
  input  logic [N_CORES*STAT_W-1:0] cycles_i,
  input  logic [N_CORES*STAT_W-1:0] miss_cycles_i,
  input  logic [N_CORES*STAT_W-1:0] write_backs_i,
  output logic [STAT_W-1:0]         accesses_o,
  output logic [STAT_W-1:0]         cycles_o,
  output logic [STAT_W-1:0]         miss_cycles_o,
  output logic [STAT_W-1:0]         write_backs_o
);
  always_comb begin
    accesses_o    = '0;
    cycles_o      = '0;
    miss_cycles_o = '0;
    write_backs_o = '0;
    for (int k = 0; k < N_CORES; k++) begin
      if (sel_i == CORE_W'(k)) begin
        accesses_o    = accesses_i[k*STAT_W +: STAT_W];
        cycles_o      = cycles_i[k*STAT_W +: STAT_W];
        miss_cycles_o = miss_cycles_i[k*STAT_W +: STAT_W];
        write_backs_o = write_backs_i[k*STAT_W +: STAT_W];
      end
    end
  end
endmodule

// File: rtl/tuner_energy_dp.sv
module tuner_energy_dp import tuner_pkg::*; #(
  parameter int STAT_W = 32,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calc_start_i,
  input  logic [STAT_W-1:0] accesses_i,
  input  logic [STAT_W-1:0] cycles_i,
  input  logic [STAT_W-1:0] miss_cycles_i,
  input  logic [STAT_W-1:0] write_backs_i,
  input  logic [COEF_W-1:0] coef_dyn_i,
  input  logic [COEF_W-1:0] coef_static_i,
  input  logic [COEF_W-1:0] coef_wb_i,
  input  logic [COEF_W-1:0] coef_fill_i,
  input  logic [COEF_W-1:0] coef_stall_i,
  output logic              calc_done_o,
  output logic [ACC_W-1:0]  energy_o
);
  localparam int TERM_W = $clog2(N_TERMS);

  logic [TERM_W-1:0] term_q;
  logic              active_q;
  logic [ACC_W-1:0]  acc_q;
  logic [STAT_W-1:0] stat_sel;
  logic [COEF_W-1:0] coef_sel;
  logic [ACC_W-1:0]  prod;

  always_comb begin
    unique case (term_q)
      TERM_W'(0): begin stat_sel = accesses_i;    coef_sel = coef_dyn_i;    end
      TERM_W'(1): begin stat_sel = cycles_i;      coef_sel = coef_static_i; end
      TERM_W'(2): begin stat_sel = write_backs_i; coef_sel = coef_wb_i;     end
      TERM_W'(3): begin stat_sel = miss_cycles_i; coef_sel = coef_fill_i;   end
      default:    begin stat_sel = miss_cycles_i; coef_sel = coef_stall_i;  end
    endcase
    prod = ACC_W'(stat_sel) * ACC_W'(coef_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q      <= '0;
      active_q    <= 1'b0;
      acc_q       <= '0;
      calc_done_o <= 1'b0;
    end else if (calc_start_i) begin
      term_q      <= '0;
      active_q    <= 1'b1;
      acc_q       <= '0;
      calc_done_o <= 1'b0;
    end else if (active_q) begin
      acc_q <= acc_q + prod;
      if (term_q == TERM_W'(N_TERMS - 1)) begin
        active_q    <= 1'b0;
        calc_done_o <= 1'b1;
      end else begin
        term_q <= term_q + 1'b1;
      end
    end else begin
      calc_done_o <= 1'b0;
    end
  end

  assign energy_o = acc_q;
endmodule

// File: rtl/tuner_fsm.sv
module tuner_fsm import tuner_pkg::*; #(
  parameter int N_CORES = 2,
  parameter int ACC_W   = 48,
  parameter int CORE_W  = 1,
  parameter int SZ_W    = 3,
  parameter int LN_W    = 2,
  parameter int WY_W    = 2,
  parameter int SZ_MAX  = 4,
  parameter int LN_MAX  = 2,
  parameter int WY_MAX  = 2,
  parameter int CFG_W   = SZ_W + LN_W + WY_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       run_done_i,
  input  logic                       calc_done_i,
  input  logic [ACC_W-1:0]           energy_i,
  output logic                       busy_o,
  output logic                       run_req_o,
  output logic                       calc_start_o,
  output logic [CORE_W-1:0]          core_sel_o,
  output logic [N_CORES*CFG_W-1:0]   cfg_o
);
  tune_st_e  state_q;
  tune_par_e par_q;
  logic [CORE_W-1:0] core_q;
  logic [SZ_W-1:0]   sz_q;
  logic [LN_W-1:0]   ln_q;
  logic [WY_W-1:0]   wy_q;
  logic [ACC_W-1:0]  best_q;
  logic [N_CORES-1:0][CFG_W-1:0] keep_q;
  logic better, at_max;

  assign better = energy_i < best_q;
  always_comb begin
    unique case (par_q)
      PAR_SIZE: at_max = sz_q == SZ_W'(SZ_MAX);
      PAR_LINE: at_max = ln_q == LN_W'(LN_MAX);
      PAR_WAYS: at_max = wy_q == WY_W'(WY_MAX);
      default:  at_max = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      par_q        <= PAR_NONE;
      core_q       <= '0;
      sz_q         <= '0;
      ln_q         <= '0;
      wy_q         <= '0;
      best_q       <= '0;
      keep_q       <= '0;
      calc_start_o <= 1'b0;
    end else begin
      calc_start_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          par_q   <= PAR_NONE;
          core_q  <= '0;
          sz_q <= '0; ln_q <= '0; wy_q <= '0;
        end
        ST_RUN: if (run_done_i) begin
          state_q      <= ST_CALC;
          calc_start_o <= 1'b1;
        end
        ST_CALC: if (calc_done_i) begin
          if (par_q == PAR_NONE) begin
            best_q  <= energy_i;
            state_q <= ST_PARAM;
          end else if (better) begin
            best_q  <= energy_i;
            state_q <= at_max ? ST_PARAM : ST_VALUE;
          end else begin
            // restore last improving value
            unique case (par_q)
              PAR_SIZE: sz_q <= sz_q - 1'b1;
              PAR_LINE: ln_q <= ln_q - 1'b1;
              default:  wy_q <= wy_q - 1'b1;
            endcase
            state_q <= ST_PARAM;
          end
        end
        ST_PARAM: if (par_q == PAR_WAYS) begin
          keep_q[core_q] <= {sz_q, ln_q, wy_q};
          if (core_q == CORE_W'(N_CORES - 1)) begin
            state_q <= ST_IDLE;
          end else begin
            core_q  <= core_q + 1'b1;
            par_q   <= PAR_NONE;
            sz_q <= '0; ln_q <= '0; wy_q <= '0;
            state_q <= ST_RUN;
          end
        end else begin
          par_q   <= tune_par_e'(par_q + 2'd1);
          state_q <= ST_VALUE;
        end
        ST_VALUE: begin
          unique case (par_q)
            PAR_SIZE: sz_q <= sz_q + 1'b1;
            PAR_LINE: ln_q <= ln_q + 1'b1;
            default:  wy_q <= wy_q + 1'b1;
          endcase
          state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign run_req_o  = state_q == ST_RUN;
  assign core_sel_o = core_q;

  for (genvar k = 0; k < N_CORES; k++) begin : g_cfg
    assign cfg_o[k*CFG_W +: CFG_W] = (busy_o && core_q == CORE_W'(k)) ?
                                     {sz_q, ln_q, wy_q} : keep_q[k];
  end
endmodule

// File: rtl/cache_tuner_ctrl.sv
module cache_tuner_ctrl #(
  parameter int N_CORES   = 2,
  parameter int STAT_W    = 32,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 48,
  parameter int SIZE_VALS = 5,
  parameter int LINE_VALS = 3,
  parameter int WAYS_VALS = 3,
  localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int SZ_W     = $clog2(SIZE_VALS),
  localparam int LN_W     = $clog2(LINE_VALS),
  localparam int WY_W     = $clog2(WAYS_VALS),
  localparam int CFG_W    = SZ_W + LN_W + WY_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      run_req_o,
  input  logic                      run_done_i,
  output logic [CORE_W-1:0]         core_sel_o,
  output logic [N_CORES*CFG_W-1:0]  cfg_o,
  input  logic [N_CORES*STAT_W-1:0] accesses_i,
  input  logic [N_CORES*STAT_W-1:0] cycles_i,
  input  logic [N_CORES*STAT_W-1:0] miss_cycles_i,
  input  logic [N_CORES*STAT_W-1:0] write_backs_i,
  input  logic [COEF_W-1:0]         coef_dyn_i,
  input  logic [COEF_W-1:0]         coef_static_i,
  input  logic [COEF_W-1:0]         coef_wb_i,
  input  logic [COEF_W-1:0]         coef_fill_i,
  input  logic [COEF_W-1:0]         coef_stall_i
);
  logic calc_start, calc_done;
  logic [ACC_W-1:0]  energy;
  logic [STAT_W-1:0] acc_s, cyc_s, miss_s, wb_s;

  tuner_stat_mux #(.N_CORES(N_CORES), .STAT_W(STAT_W), .CORE_W(CORE_W)) u_mux (
    .sel_i(core_sel_o), .accesses_i(accesses_i), .cycles_i(cycles_i),
    .miss_cycles_i(miss_cycles_i), .write_backs_i(write_backs_i),
    .accesses_o(acc_s), .cycles_o(cyc_s), .miss_cycles_o(miss_s),
    .write_backs_o(wb_s)
  );

  tuner_energy_dp #(.STAT_W(STAT_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .calc_start_i(calc_start),
    .accesses_i(acc_s), .cycles_i(cyc_s), .miss_cycles_i(miss_s),
    .write_backs_i(wb_s), .coef_dyn_i(coef_dyn_i), .coef_static_i(coef_static_i),
    .coef_wb_i(coef_wb_i), .coef_fill_i(coef_fill_i), .coef_stall_i(coef_stall_i),
    .calc_done_o(calc_done), .energy_o(energy)
  );

  tuner_fsm #(
    .N_CORES(N_CORES), .ACC_W(ACC_W), .CORE_W(CORE_W),
    .SZ_W(SZ_W), .LN_W(LN_W), .WY_W(WY_W),
    .SZ_MAX(SIZE_VALS - 1), .LN_MAX(LINE_VALS - 1), .WY_MAX(WAYS_VALS - 1),
    .CFG_W(CFG_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .run_done_i(run_done_i),
    .calc_done_i(calc_done), .energy_i(energy), .busy_o(busy_o),
    .run_req_o(run_req_o), .calc_start_o(calc_start), .core_sel_o(core_sel_o),
    .cfg_o(cfg_o)
  );
endmodule

// File: rtl/tuner_chk.sv
module tuner_chk #(
  parameter int N_CORES = 2,
  parameter int CORE_W  = 1,
  parameter int SZ_W    = 3,
  parameter int LN_W    = 2,
  parameter int WY_W    = 2,
  parameter int SZ_MAX  = 4,
  parameter int LN_MAX  = 2,
  parameter int WY_MAX  = 2,
  parameter int CFG_W   = SZ_W + LN_W + WY_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     run_req_o,
  input logic                     run_done_i,
  input logic [CORE_W-1:0]        core_sel_o,
  input logic [N_CORES*CFG_W-1:0] cfg_o,
  input logic                     calc_start,
  input logic                     calc_done
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o); // R2
  AST_MAC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_done |-> $past(calc_start, 6)); // R4
  AST_CORE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && core_sel_o != $past(core_sel_o)
      |-> core_sel_o == $past(core_sel_o) + 1'b1); // R8
  AST_REQ_IN_SESSION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o |-> busy_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o && !run_done_i |=> run_req_o); // R9
  AST_CFG_STABLE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o && $past(run_req_o) |-> $stable(cfg_o)); // R9
  AST_IDLE_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(cfg_o)); // R10

  for (genvar k = 0; k < N_CORES; k++) begin : g_rng
    AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[k*CFG_W+LN_W+WY_W +: SZ_W] <= SZ_W'(SZ_MAX) &&
      cfg_o[k*CFG_W+WY_W +: LN_W] <= LN_W'(LN_MAX) &&
      cfg_o[k*CFG_W +: WY_W] <= WY_W'(WY_MAX)); // R7
  end
endmodule

bind cache_tuner_ctrl tuner_chk #(
  .N_CORES(N_CORES), .CORE_W(CORE_W), .SZ_W(SZ_W), .LN_W(LN_W), .WY_W(WY_W),
  .SZ_MAX(SIZE_VALS - 1), .LN_MAX(LINE_VALS - 1), .WY_MAX(WAYS_VALS - 1),
  .CFG_W(CFG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .run_req_o(run_req_o), .run_done_i(run_done_i), .core_sel_o(core_sel_o),
  .cfg_o(cfg_o), .calc_start(calc_start), .calc_done(calc_done)
);

// File: tb/cache_tuner_ctrl_bench.sv
`timescale 1ns/1ps
module cache_tuner_ctrl_bench;
  localparam int NC = 2;
  localparam int SW = 32;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic run_done = 1'b0;
  logic busy, run_req;
  logic [0:0] core_sel;
  logic [NC*CW-1:0] cfg;
  logic [NC*SW-1:0] acc_v, cyc_v, miss_v, wb_v;
  logic [15:0] c_dyn, c_st, c_wb, c_fill, c_stall;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int exp_q[$];
  int exp_final[NC];
  int tsz[NC][5];
  int tln[NC][3];
  int tas[NC][3];

  always #2.5 clk = ~clk;

  cache_tuner_ctrl u_cache_tuner_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy),
    .run_req_o(run_req), .run_done_i(run_done), .core_sel_o(core_sel),
    .cfg_o(cfg), .accesses_i(acc_v), .cycles_i(cyc_v),
    .miss_cycles_i(miss_v), .write_backs_i(wb_v),
    .coef_dyn_i(c_dyn), .coef_static_i(c_st), .coef_wb_i(c_wb),
    .coef_fill_i(c_fill), .coef_stall_i(c_stall)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // statistics of a run, as the requirements define them
  function automatic longint st_acc(int c, int s);  return 1000 + tsz[c][s]; endfunction
  function automatic longint st_cyc(int c, int l);  return 700 + tln[c][l];  endfunction
  function automatic longint st_wb(int c, int l);   return 11 + tln[c][l];   endfunction
  function automatic longint st_miss(int c, int a); return 13 + tas[c][a];   endfunction

  function automatic longint energy(int c, int s, int l, int a);
    return st_acc(c, s) * c_dyn + st_cyc(c, l) * c_st + st_wb(c, l) * c_wb +
           st_miss(c, a) * c_fill + st_miss(c, a) * c_stall;
  endfunction

  function automatic int code(int c, int s, int l, int a);
    return c * 256 + s * 16 + l * 4 + a;
  endfunction

  // driver: greedy search model, pushes the expected trial sequence
  task automatic plan_session();
    for (int c = 0; c < NC; c++) begin
      int idx[3];
      int mx[3];
      longint best;
      longint e;
      idx = '{0, 0, 0};
      mx  = '{4, 2, 2};
      exp_q.push_back(code(c, 0, 0, 0));
      best = energy(c, 0, 0, 0);
      for (int p = 0; p < 3; p++) begin
        while (idx[p] < mx[p]) begin
          idx[p]++;
          exp_q.push_back(code(c, idx[0], idx[1], idx[2]));
          e = energy(c, idx[0], idx[1], idx[2]);
          if (e < best) best = e;
          else begin idx[p]--; break; end
        end
      end
      exp_final[c] = idx[0] * 16 + idx[1] * 4 + idx[2];
    end
  endtask

  // monitor: compare each new run request against the scoreboard
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (run_req && !prev) begin
        int got;
        got = int'(core_sel) * 256 + int'(cfg[core_sel*CW +: CW]);
        if (exp_q.size() == 0) check("R3 R8 unexpected run", got, -1);
        else check("R3 R5 R6 R8 trial config", got, exp_q.pop_front());
      end
      prev = run_req;
    end
  end

  // responder: runs the workload model for the requested setting
  initial begin
    forever begin
      @(negedge clk);
      if (run_req) begin
        int c, s, l, a;
        c = int'(core_sel);
        s = int'(cfg[c*CW+4 +: 3]);
        l = int'(cfg[c*CW+2 +: 2]);
        a = int'(cfg[c*CW +: 2]);
        acc_v = '1; cyc_v = '1; miss_v = '1; wb_v = '1;
        acc_v[c*SW +: SW]  = SW'(st_acc(c, s));
        cyc_v[c*SW +: SW]  = SW'(st_cyc(c, l));
        wb_v[c*SW +: SW]   = SW'(st_wb(c, l));
        miss_v[c*SW +: SW] = SW'(st_miss(c, a));
        repeat (2) @(negedge clk);
        check("R9 request held until done", run_req, 1);
        run_done = 1'b1;
        @(negedge clk);
        run_done = 1'b0;
      end
    end
  end

  task automatic run_session(string tag);
    plan_session();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 busy after start", busy, 1);
    while (busy) @(negedge clk);
    check("R10 no request after end", run_req, 0);
    check("R3 all trials seen", exp_q.size(), 0);
    for (int c = 0; c < NC; c++)
      check({"R4 R5 R6 R7 R8 final config ", tag}, cfg[c*CW +: CW], exp_final[c]);
    repeat (5) @(negedge clk);
    for (int c = 0; c < NC; c++)
      check("R10 final config held", cfg[c*CW +: CW], exp_final[c]);
    check("R1 idle after session", busy, 0);
  endtask

  initial begin
    c_dyn = 16'd3; c_st = 16'd2; c_wb = 16'd5; c_fill = 16'd4; c_stall = 16'd7;
    acc_v = '1; cyc_v = '1; miss_v = '1; wb_v = '1;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset request", run_req, 0);
    check("R1 reset config", cfg, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle without start", busy, 0);
    check("R1 no request without start", run_req, 0);

    // session 1: midway stop, max reach, early reject, tie on size
    tsz[0] = '{50, 40, 30, 35, 10}; tln[0] = '{20, 15, 12}; tas[0] = '{5, 8, 1};
    tsz[1] = '{10, 10, 3, 2, 1};    tln[1] = '{9, 3, 7};    tas[1] = '{9, 6, 2};
    run_session("s1");

    // session 2: size climbs to top, tie on line, other coefficients
    c_dyn = 16'd1; c_st = 16'd9; c_wb = 16'd2; c_fill = 16'd6; c_stall = 16'd1;
    tsz[0] = '{40, 30, 20, 10, 5};  tln[0] = '{5, 5, 1};    tas[0] = '{9, 3, 4};
    tsz[1] = '{5, 9, 1, 1, 1};      tln[1] = '{8, 4, 2};    tas[1] = '{2, 2, 2};
    run_session("s2");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", busy, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule